// File: doc/BRIEF.md
# Host-Slave Mailbox with Handshake Flags

This block joins a host bus and a local slave processor bus through a small set of shared registers. The host sends single bytes to the slave through an inbound byte register, which it can write through either a data port or a command port. The slave sends single bytes back through an outbound byte register. A sixteen-byte shared buffer carries longer messages in either direction. An 8-bit status word shows the handshake flags to both sides.

Each flag is set and cleared by specific accesses made by the two sides. The shared buffer is owned by one writer at a time. A side claims the buffer by writing byte 0. Ownership ends when the other side reads the last byte, and the slave can also release its own claim by clearing the flag.

Both buses are modelled as synchronous read and write strobes with a 5-bit byte address. Read data is combinational from the current register state. Every flag change takes effect at the clock edge that samples the strobe.

Top module: `mbox_hs`

## Requirements
- R1: After reset, the status word and every data register read as 0x00.
- R2: Status word layout, from bit 7 down to bit 0: buffer-inbound-full, buffer-outbound-full, host-owns-buffer, slave-owns-buffer, command flag, spare flag, inbound-full, outbound-full. The host reads it at address 0x02 and the slave at address 0x02.
- R3: A host write to address 0x00 (data port) or 0x01 (command port) stores the byte, sets inbound-full, and loads the command flag with address bit 0. A slave read of address 0x00 returns the byte and clears inbound-full.
- R4: A slave write to address 0x01 stores the outbound byte and sets outbound-full. A host read of address 0x00 or 0x01 returns that byte and clears outbound-full.
- R5: A slave write to the status word clears outbound-full (bit 0), slave-owns-buffer (bit 4) and buffer-outbound-full (bit 6) where the written bit is 0, and leaves them unchanged where it is 1. It stores bit 2 in the spare flag and ignores all other bits. A host write to address 0x02 has no effect.
- R6: When a set condition and a clear condition for the same flag occur in the same cycle, the flag ends up set.
- R7: A host write to buffer byte 0 sets host-owns-buffer when slave-owns-buffer is 0. A slave read of the last buffer byte clears host-owns-buffer.
- R8: A slave write to buffer byte 0 sets slave-owns-buffer when host-owns-buffer is 0 and the host is not claiming the buffer in the same cycle. A host read of the last byte clears slave-owns-buffer, and so does a slave status write with bit 4 equal to 0.
- R9: The two ownership flags are never both 1. A write to byte 0 by the side that does not own the buffer still stores the byte but leaves both ownership flags unchanged. When both sides claim in the same cycle, the host wins.
- R10: A host write to the last buffer byte sets buffer-inbound-full. A slave read of the last byte clears it.
- R11: A slave write to the last buffer byte sets buffer-outbound-full. A host read of the last byte clears it, and so does a slave status write with bit 6 equal to 0.
- R12: Buffer byte n is at address 0x10+n on both sides and can be read and written by both. When both sides write the same byte in the same cycle, the host's byte is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_addr | input | 5 | Host byte address |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data |
| s_wr | input | 1 | Slave write strobe |
| s_rd | input | 1 | Slave read strobe |
| s_addr | input | 5 | Slave byte address |
| s_wdata | input | 8 | Slave write data |
| s_rdata | output | 8 | Slave read data |

## Verification
The assertions assume that each side raises at most one of its read and write strobes in a cycle, and that reads take effect only on the strobed cycle. The bench drives every access as a one-cycle pulse on exactly one strobe per side. When it tests collisions, it pulses both sides in the same cycle, either on the same byte or on the same flag. Addresses outside the defined map are never driven, so the assertions never see an undefined decode.

// File: rtl/mbox_hs.sv
module mbox_hs #(
  parameter int NBUF = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       h_wr,
  input  logic       h_rd,
  input  logic [4:0] h_addr,
  input  logic [7:0] h_wdata,
  output logic [7:0] h_rdata,
  input  logic       s_wr,
  input  logic       s_rd,
  input  logic [4:0] s_addr,
  input  logic [7:0] s_wdata,
  output logic [7:0] s_rdata
);
  localparam int BW   = $clog2(NBUF);
  localparam int LAST = NBUF - 1;

  logic [7:0] idr, odr;
  logic [7:0] tbuf [NBUF];
  logic bif, bof, mwm, swm, cmd, usr, ibf, obf;
  logic [7:0] st;

  wire          h_buf = h_addr[BW];
  wire          s_buf = s_addr[BW];
  wire [BW-1:0] h_idx = h_addr[BW-1:0];
  wire [BW-1:0] s_idx = s_addr[BW-1:0];

  wire h_wr_idr = h_wr && !h_buf && (h_idx[BW-1:1] == '0);
  wire h_rd_odr = h_rd && !h_buf && (h_idx[BW-1:1] == '0);
  wire s_rd_idr = s_rd && !s_buf && (s_idx == BW'(0));
  wire s_wr_odr = s_wr && !s_buf && (s_idx == BW'(1));
  wire s_wr_st  = s_wr && !s_buf && (s_idx == BW'(2));

  wire h_wr_b0   = h_wr && h_buf && (h_idx == '0);
  wire s_wr_b0   = s_wr && s_buf && (s_idx == '0);
  wire h_wr_last = h_wr && h_buf && (h_idx == BW'(LAST));
  wire s_wr_last = s_wr && s_buf && (s_idx == BW'(LAST));
  wire h_rd_last = h_rd && h_buf && (h_idx == BW'(LAST));
  wire s_rd_last = s_rd && s_buf && (s_idx == BW'(LAST));

  wire h_claim = h_wr_b0 && !swm;
  wire s_claim = s_wr_b0 && !mwm && !h_claim;

  assign st = {bif, bof, mwm, swm, cmd, usr, ibf, obf};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idr <= '0;
      odr <= '0;
      {bif, bof, mwm, swm, cmd, usr, ibf, obf} <= '0;
    end else begin
      if (h_wr_idr) begin
        idr <= h_wdata;
        cmd <= h_addr[0];
      end
      if (s_wr_odr) odr <= s_wdata;
      if (s_wr_st) usr <= s_wdata[2];

      ibf <= h_wr_idr  ? 1'b1 : s_rd_idr ? 1'b0 : ibf;
      obf <= s_wr_odr  ? 1'b1 : (h_rd_odr || (s_wr_st && !s_wdata[0])) ? 1'b0 : obf;
      mwm <= h_claim   ? 1'b1 : s_rd_last ? 1'b0 : mwm;
      swm <= s_claim   ? 1'b1 : (h_rd_last || (s_wr_st && !s_wdata[4])) ? 1'b0 : swm;
      bif <= h_wr_last ? 1'b1 : s_rd_last ? 1'b0 : bif;
      bof <= s_wr_last ? 1'b1 : (h_rd_last || (s_wr_st && !s_wdata[6])) ? 1'b0 : bof;
    end
  end

  for (genvar i = 0; i < NBUF; i++) begin : g_buf
    always_ff @(posedge clk) begin
      if (!rst_n) tbuf[i] <= '0;
      else if (h_wr && h_buf && h_idx == BW'(i)) tbuf[i] <= h_wdata;
      else if (s_wr && s_buf && s_idx == BW'(i)) tbuf[i] <= s_wdata;
    end
  end

  always_comb begin
    if (h_buf)                  h_rdata = tbuf[h_idx];
    else if (h_idx == BW'(2))   h_rdata = st;
    else if (h_idx[BW-1:1] == '0) h_rdata = odr;
    else                        h_rdata = '0;
  end

  always_comb begin
    if (s_buf)                  s_rdata = tbuf[s_idx];
    else if (s_idx == BW'(0))   s_rdata = idr;
    else if (s_idx == BW'(1))   s_rdata = odr;
    else if (s_idx == BW'(2))   s_rdata = st;
    else                        s_rdata = '0;
  end

  p_owner_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mwm && swm));

  p_ibf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    h_wr_idr |=> ibf);

  p_swm_claim_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(swm) |-> $past(!mwm));

  p_obf_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s_wr_st && s_wdata[0] && !h_rd_odr) |=> $stable(obf));

  p_bif_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    h_wr_last |=> bif);

  p_mwm_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mwm && !s_rd_last) |=> mwm);

  p_obf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    s_wr_odr |=> obf);
endmodule

// File: tb/test_mbox_hs.sv
`timescale 1ns/1ps
module test_mbox_hs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_wr = 0, h_rd = 0, s_wr = 0, s_rd = 0;
  logic [4:0] h_addr = '0, s_addr = '0;
  logic [7:0] h_wdata = '0, s_wdata = '0;
  logic [7:0] h_rdata, s_rdata;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [7:0] qh_exp[$];
  string      qh_tag[$];
  logic [7:0] qs_exp[$];
  string      qs_tag[$];

  always #2 clk = ~clk;

  mbox_hs i_mbox_hs (
    .clk(clk), .rst_n(rst_n),
    .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .s_wr(s_wr), .s_rd(s_rd), .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata)
  );

  task automatic drive(input logic hw, input logic hr, input logic [4:0] ha, input logic [7:0] hd,
                       input logic [7:0] hx, input string ht,
                       input logic sw, input logic sr, input logic [4:0] sa, input logic [7:0] sd,
                       input logic [7:0] sx, input string stg);
    @(posedge clk); #1;
    h_wr = hw; h_rd = hr; h_addr = ha; h_wdata = hd;
    s_wr = sw; s_rd = sr; s_addr = sa; s_wdata = sd;
    if (hr) begin qh_exp.push_back(hx); qh_tag.push_back(ht); end
    if (sr) begin qs_exp.push_back(sx); qs_tag.push_back(stg); end
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, "", 0, 0, 0, 0, 0, "");
  endtask
  task automatic hwr(input logic [4:0] a, input logic [7:0] d);
    drive(1, 0, a, d, 0, "", 0, 0, 0, 0, 0, "");
  endtask
  task automatic hrd(input logic [4:0] a, input logic [7:0] x, input string t);
    drive(0, 1, a, 0, x, t, 0, 0, 0, 0, 0, "");
  endtask
  task automatic swr(input logic [4:0] a, input logic [7:0] d);
    drive(0, 0, 0, 0, 0, "", 1, 0, a, d, 0, "");
  endtask
  task automatic srd(input logic [4:0] a, input logic [7:0] x, input string t);
    drive(0, 0, 0, 0, 0, "", 0, 1, a, 0, x, t);
  endtask

  always @(negedge clk) begin
    if (rst_n && h_rd && qh_exp.size() > 0) begin
      logic [7:0] e;
      string t;
      e = qh_exp.pop_front(); t = qh_tag.pop_front();
      checks++;
      if (h_rdata !== e) begin
        fails++;
        $display("FAIL %s (host): got %02h expected %02h", t, h_rdata, e);
      end
    end
    if (rst_n && s_rd && qs_exp.size() > 0) begin
      logic [7:0] e;
      string t;
      e = qs_exp.pop_front(); t = qs_tag.pop_front();
      checks++;
      if (s_rdata !== e) begin
        fails++;
        $display("FAIL %s (slave): got %02h expected %02h", t, s_rdata, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 R2 reset state
    srd(5'h02, 8'h00, "R1 slave status");
    hrd(5'h02, 8'h00, "R1 host status");
    srd(5'h00, 8'h00, "R1 inbound reg");
    hrd(5'h1F, 8'h00, "R1 buffer last");

    // R3 inbound via command port then data port
    hwr(5'h01, 8'hA5);
    hrd(5'h02, 8'h0A, "R3 cmd+ibf R2");
    srd(5'h00, 8'hA5, "R3 inbound data");
    hrd(5'h02, 8'h08, "R3 ibf cleared");
    hwr(5'h00, 8'h3C);
    srd(5'h02, 8'h02, "R3 data port cmd=0");
    srd(5'h00, 8'h3C, "R3 inbound data2");
    srd(5'h02, 8'h00, "R3 cleared");

    // R4 R5 outbound and slave status writes
    swr(5'h01, 8'h5A);
    hrd(5'h02, 8'h01, "R4 obf set");
    swr(5'h02, 8'hFF);
    hrd(5'h02, 8'h05, "R5 write 1 keeps obf, spare set");
    hrd(5'h00, 8'h5A, "R4 outbound data");
    hrd(5'h02, 8'h04, "R4 obf cleared");
    swr(5'h01, 8'h66);
    swr(5'h02, 8'h04);
    hrd(5'h02, 8'h04, "R5 write 0 clears obf");
    hwr(5'h02, 8'hFF);
    srd(5'h02, 8'h04, "R5 host status write ignored");
    swr(5'h02, 8'h00);
    srd(5'h02, 8'h00, "R5 spare cleared");

    // R6 slave sets obf while host reads it
    drive(0, 1, 5'h00, 0, 8'h66, "R6 old outbound", 1, 0, 5'h01, 8'h11, 0, "");
    srd(5'h02, 8'h01, "R6 set wins obf");
    hrd(5'h01, 8'h11, "R4 outbound via cmd port");
    srd(5'h02, 8'h00, "R4 cleared");

    // R7 R9 R10 host-owned buffer
    hwr(5'h10, 8'h80);
    srd(5'h02, 8'h20, "R7 host owns");
    swr(5'h10, 8'h99);
    srd(5'h02, 8'h20, "R9 non-owner no flag change");
    hrd(5'h10, 8'h99, "R9 non-owner byte stored");
    hwr(5'h1F, 8'hF0);
    hrd(5'h02, 8'hA0, "R10 bif set");
    srd(5'h1F, 8'hF0, "R12 last byte");
    hrd(5'h02, 8'h00, "R7 R10 cleared by slave read");
    hwr(5'h15, 8'h55);
    srd(5'h15, 8'h55, "R12 middle byte");

    // R8 R11 slave-owned buffer
    swr(5'h10, 8'h01);
    hrd(5'h02, 8'h10, "R8 slave owns");
    hwr(5'h10, 8'h77);
    hrd(5'h02, 8'h10, "R9 host no claim");
    swr(5'h1F, 8'h0F);
    hrd(5'h02, 8'h50, "R11 bof set");
    swr(5'h02, 8'hFF);
    hrd(5'h02, 8'h54, "R5 write 1 keeps swm bof");
    hrd(5'h1F, 8'h0F, "R12 host reads last");
    srd(5'h02, 8'h04, "R8 R11 cleared by host read");
    swr(5'h02, 8'h00);
    swr(5'h10, 8'h02);
    swr(5'h02, 8'h00);
    srd(5'h02, 8'h00, "R8 cleared by status write");
    swr(5'h1F, 8'h03);
    srd(5'h02, 8'h40, "R11 bof set again");
    swr(5'h02, 8'h00);
    srd(5'h02, 8'h00, "R11 cleared by status write");

    // R9 R12 simultaneous claim and same-byte write
    drive(1, 0, 5'h10, 8'hAA, 0, "", 1, 0, 5'h10, 8'hBB, 0, "");
    hrd(5'h02, 8'h20, "R9 host wins claim");
    srd(5'h10, 8'hAA, "R12 host byte kept");
    srd(5'h1F, 8'h03, "R7 release read");
    hrd(5'h02, 8'h00, "R7 released");

    // R6 bif set and clear same cycle
    drive(1, 0, 5'h1F, 8'hC3, 0, "", 0, 1, 5'h1F, 0, 8'h03, "R6 old last byte");
    hrd(5'h02, 8'h80, "R6 set wins bif");
    srd(5'h1F, 8'hC3, "R10 read clears");
    hrd(5'h02, 8'h00, "R10 cleared");

    idle();
    idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule